// File: doc/BRIEF.md
# Bit-Masked Planar Pattern Writer

This block is the write path in front of a four-plane display memory whose storage has a separate write enable for every bit. Each memory word is 32 bits wide and holds one 8-bit byte per plane. A CPU byte write turns into exactly one memory write cycle. The block never reads memory first.

The block has two write styles. In plain mode, the CPU byte goes to every plane. A plane-enable mask then decides which planes take it, at whole-byte granularity. In stamp mode, the CPU byte is not data. It is a bit mask. At each bit position set in the byte, all four planes receive the matching bit of a 32-bit pattern that was loaded earlier. Every other bit position keeps its stored value. Software can therefore paint any set of pixels in any of the sixteen colours with a single write, and no read is needed.

A small register port holds the settings: the four pattern bytes, the mode bit and the plane-enable mask. The CPU byte path and the register port are separate. The memory side receives a write strobe, an address, 32 data bits and 32 per-bit write enables, all one clock after the CPU write.

Top module: `ppw_pattern_writer`

## Requirements
- R1: After reset, the mem outputs are all zero. The pattern bytes are zero, the mode is plain, and the plane-enable mask is all ones.
- R2: A register-port write loads a setting. Addresses 0 to 3 load the pattern byte of plane 0 to 3. Address 4 loads the mode from data bit 0, where 0 is plain and 1 is stamp. Address 5 loads the plane-enable mask from data bits 3:0, where bit p belongs to plane p. Writes to addresses 6 and 7 change nothing.
- R3: A CPU write sampled at a clock edge raises mem_we for exactly the following cycle. In that cycle mem_addr equals the CPU address. A cycle with no CPU write produces no memory write.
- R4: In plain mode, every plane's data byte equals the CPU byte. Plane p occupies mem_wdata bits 8p+7 down to 8p.
- R5: In plain mode, the eight write enables of plane p (mem_bit_we bits 8p+7 down to 8p) are all 1 when mask bit p is 1, and all 0 otherwise.
- R6: In stamp mode, the data byte of plane p equals pattern byte p. The CPU byte does not affect the data.
- R7: In stamp mode, write-enable bit b of every plane equals bit b of the CPU byte. The plane-enable mask has no effect.
- R8: While mem_we is 0, every bit of mem_bit_we is 0.
- R9: A CPU write in the same cycle as a register-port write uses the settings held before that register update.
- R10: CPU writes on consecutive cycles produce consecutive memory cycles. Each cycle carries its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU byte (data in plain mode, bit mask in stamp mode) |
| mem_we | output | 1 | Memory write cycle strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Data for the four planes |
| mem_bit_we | output | 32 | Per-bit write enables |

## Verification
In plain mode, every CPU byte value is written under each of the sixteen plane-enable masks. This separates per-plane gating errors from data routing errors. In stamp mode, every mask byte is swept against an all-zero pattern, an all-one pattern and two mixed patterns. The plane-enable mask is set to both extremes in this sweep, which shows that it has no effect and that each plane takes its own pattern byte. Further directed sequences cover the following cases:
- writes to the unused register addresses;
- a register update in the same cycle as a CPU write;
- back-to-back writes;
- the idle cycle after each write.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
    parameter int PLANES  = 4;
    parameter int PLANE_W = 8;

    localparam int PAT_W  = PLANES * PLANE_W;
    localparam int CFG_AW = $clog2(PLANES + 4);
    localparam logic [CFG_AW-1:0] MODE_SEL = CFG_AW'(PLANES);
    localparam logic [CFG_AW-1:0] PEN_SEL  = CFG_AW'(PLANES + 1);

    typedef enum logic {
        WM_PLAIN = 1'b0,
        WM_STAMP = 1'b1
    } wmode_e;

    typedef struct packed {
        logic [PLANES-1:0][PLANE_W-1:0] pat;
        wmode_e                         mode;
        logic [PLANES-1:0]              pen;
    } cfg_t;

    typedef struct packed {
        logic                           we;
        logic [PLANES-1:0][PLANE_W-1:0] wdata;
        logic [PLANES-1:0][PLANE_W-1:0] bwe;
    } wr_t;
endpackage

// File: rtl/ppw_cfg_regs.sv
module ppw_cfg_regs
    import ppw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [PLANE_W-1:0] cfg_wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int p = 0; p < PLANES; p++) begin
                if (cfg_addr == CFG_AW'(p)) begin
                    cfg_d.pat[p] = cfg_wdata;
                end
            end
            if (cfg_addr == MODE_SEL) begin
                cfg_d.mode = wmode_e'(cfg_wdata[0]);
            end
            if (cfg_addr == PEN_SEL) begin
                cfg_d.pen = cfg_wdata[PLANES-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mode <= WM_PLAIN;
            cfg_q.pen  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == MODE_SEL |=> cfg_q.mode == wmode_e'($past(cfg_wdata[0])));

    // R2
    pen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == PEN_SEL |=> cfg_q.pen == $past(cfg_wdata[PLANES-1:0]));

    // R2
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr > PEN_SEL |=> $stable(cfg_q));
endmodule

// File: rtl/ppw_lane.sv
module ppw_lane
    import ppw_pkg::*;
(
    input  wmode_e             mode,
    input  logic               plane_en,
    input  logic [PLANE_W-1:0] pat_byte,
    input  logic [PLANE_W-1:0] cpu_byte,
    output logic [PLANE_W-1:0] lane_wdata,
    output logic [PLANE_W-1:0] lane_bwe
);
    always_comb begin
        if (mode == WM_STAMP) begin
            lane_wdata = pat_byte;
            lane_bwe   = cpu_byte;
        end else begin
            lane_wdata = cpu_byte;
            lane_bwe   = {PLANE_W{plane_en}};
        end
    end
endmodule

// File: rtl/ppw_out_stage.sv
module ppw_out_stage
    import ppw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [PAT_W-1:0]  lane_wdata,
    input  logic [PAT_W-1:0]  lane_bwe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PAT_W-1:0]  mem_wdata,
    output logic [PAT_W-1:0]  mem_bit_we
);
    wr_t               wr_d, wr_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        wr_d   = wr_q;
        addr_d = addr_q;
        if (cpu_we) begin
            wr_d.we    = 1'b1;
            wr_d.wdata = lane_wdata;
            wr_d.bwe   = lane_bwe;
            addr_d     = cpu_addr;
        end else begin
            wr_d.we  = 1'b0;
            wr_d.bwe = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            addr_q <= '0;
        end else begin
            wr_q   <= wr_d;
            addr_q <= addr_d;
        end
    end

    assign mem_we     = wr_q.we;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wr_q.wdata;
    assign mem_bit_we = wr_q.bwe;

    // R8
    idle_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> mem_bit_we == '0);

    // R3
    addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> mem_addr == $past(cpu_addr));
endmodule

// File: rtl/ppw_pattern_writer.sv
module ppw_pattern_writer
    import ppw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [PLANE_W-1:0]  cfg_wdata,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [PLANE_W-1:0]  cpu_data,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [PAT_W-1:0]    mem_wdata,
    output logic [PAT_W-1:0]    mem_bit_we
);
    cfg_t             cfg;
    logic [PAT_W-1:0] lane_wdata;
    logic [PAT_W-1:0] lane_bwe;
    logic [PAT_W-1:0] pat_flat;

    ppw_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    assign pat_flat = cfg.pat;

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        ppw_lane u_lane (
            .mode       (cfg.mode),
            .plane_en   (cfg.pen[p]),
            .pat_byte   (cfg.pat[p]),
            .cpu_byte   (cpu_data),
            .lane_wdata (lane_wdata[p*PLANE_W +: PLANE_W]),
            .lane_bwe   (lane_bwe[p*PLANE_W +: PLANE_W])
        );
    end

    ppw_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .lane_wdata (lane_wdata),
        .lane_bwe   (lane_bwe),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_bit_we (mem_bit_we)
    );

    // R3
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> mem_we);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> !mem_we);

    // R4
    plain_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we && cfg.mode == WM_PLAIN |=> mem_wdata == {PLANES{$past(cpu_data)}});

    // R6
    stamp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we && cfg.mode == WM_STAMP |=> mem_wdata == $past(pat_flat));

    // R7
    stamp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we && cfg.mode == WM_STAMP |=> mem_bit_we == {PLANES{$past(cpu_data)}});
endmodule

// File: tb/ppw_pattern_writer_tb_top.sv
module ppw_pattern_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_bit_we;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    logic [31:0] m_pat = '0;
    logic        m_mode = 1'b0;
    logic [3:0]  m_pen = 4'hF;

    always #5 clk = ~clk;

    ppw_pattern_writer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_bit_we(mem_bit_we)
    );

    function automatic logic [31:0] exp_wd(input logic [7:0] d);
        return m_mode ? m_pat : {4{d}};
    endfunction

    function automatic logic [31:0] exp_be(input logic [7:0] d);
        logic [31:0] be;
        if (m_mode) return {4{d}};
        for (int p = 0; p < 4; p++) be[p*8 +: 8] = {8{m_pen[p]}};
        return be;
    endfunction

    task automatic chk(input string req, input logic [80:0] act, input logic [80:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [80:0] outs();
        return {mem_we, mem_addr, mem_wdata, mem_bit_we};
    endfunction

    task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3'd4) m_pat[a*8 +: 8] = d;
        else if (a == 3'd4) m_mode = d[0];
        else if (a == 3'd5) m_pen = d[3:0];
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_we = 1'b0;
        chk(req, outs(), {1'b1, a, exp_wd(d), exp_be(d)});
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk("R8 idle", {mem_we, 16'h0, 32'h0, mem_bit_we}, 81'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle, defaults plain / all planes on / zero pattern
        chk("R1 reset outputs", outs(), 81'h0);
        wr(16'h0001, 8'h3C, "R1 default plain all planes");
        idle_chk();
        cfg_wr(3'd4, 8'h01);
        wr(16'h0002, 8'hFF, "R1 pattern zero after reset");
        cfg_wr(3'd4, 8'h00);

        // R4 R5: plain sweep over all plane masks and bytes
        for (int pen = 0; pen < 16; pen++) begin
            cfg_wr(3'd5, 8'(pen));
            for (int d = 0; d < 256; d++) begin
                wr(16'(pen * 256 + d), 8'(d), "R4 R5 plain");
                if (d % 64 == 0) idle_chk();
            end
        end

        // R2 R6 R7: stamp sweep, several patterns, plane mask ignored
        cfg_wr(3'd4, 8'h01);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            case (k)
                0: pat = 32'h0000_0000;
                1: pat = 32'hFFFF_FFFF;
                2: pat = 32'h1234_A5C3;
                default: pat = 32'h8F70_0E69;
            endcase
            for (int p = 0; p < 4; p++) cfg_wr(3'(p), pat[p*8 +: 8]);
            cfg_wr(3'd5, (k % 2 == 0) ? 8'h00 : 8'h0F);
            for (int d = 0; d < 256; d++) begin
                wr(16'(16'h8000 + k * 256 + d), 8'(d), "R6 R7 stamp");
            end
        end

        // R2: unused addresses change nothing (pattern, mode, plane mask)
        cfg_wr(3'd5, 8'h05);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 8'hAA;
        @(negedge clk); cfg_addr = 3'd7; cfg_wdata = 8'h00;
        @(negedge clk); cfg_we = 1'b0;
        wr(16'h4444, 8'h81, "R2 unused addr stamp intact");
        cfg_wr(3'd4, 8'h00);
        wr(16'h4445, 8'h66, "R2 unused addr plane mask intact");

        // R9: register update in same cycle as a CPU write
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 8'h01;
        cpu_we = 1'b1; cpu_addr = 16'h0909; cpu_data = 8'h5A;
        @(negedge clk);
        cfg_we = 1'b0; cpu_we = 1'b0;
        chk("R9 old settings", outs(), {1'b1, 16'h0909, exp_wd(8'h5A), exp_be(8'h5A)});
        m_mode = 1'b1;
        wr(16'h090A, 8'h5A, "R9 new settings next write");

        // R10: back-to-back writes
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'h1111; cpu_data = 8'h0F;
        @(negedge clk);
        cpu_addr = 16'h2222; cpu_data = 8'hF0;
        chk("R10 first", outs(), {1'b1, 16'h1111, exp_wd(8'h0F), exp_be(8'h0F)});
        @(negedge clk);
        cpu_we = 1'b0;
        chk("R10 second", outs(), {1'b1, 16'h2222, exp_wd(8'hF0), exp_be(8'hF0)});
        // R3: single cycle strobe
        @(negedge clk);
        chk("R3 strobe drops", {mem_we, 80'h0}, 81'h0);
        idle_chk();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule